// File: doc/BRIEF.md
# Four-Way Cache Victim Selector

This block tells a 4-way set-associative cache which way to evict in the set it is refilling. The cache controller strobes a lookup with the set index and the full access address. One cycle later the block returns the chosen way. The controller also reports every hit (set and way) and every refill (set and way) it performs, and it can request a flush that returns all replacement history to its initial state. The tag and data arrays, miss handling and the memory bus belong to the surrounding cache and are not part of this block.

The replacement rule is fixed at elaboration by the `POLICY` parameter, and there are four choices:

- A pseudo-random pick taken from a free-running shift register.
- A pick taken straight from two address bits.
- A per-set round-robin over refills.
- A true least-recently-used order per set.

The LRU order of the four ways in a set has 24 possible permutations. It is held as a 5-bit rank code per set rather than as a pairwise age matrix. The number of sets follows from the way size and the line size.

Top module: `cache_victim_sel`

## Requirements
- R1: `victim_valid_o` is 1 exactly in the cycle after a cycle with `lookup_i` high and is 0 otherwise. `victim_o` changes only in the cycle after a lookup and otherwise keeps its last value.
- R2: With the random policy, a 16-bit shift register is seeded to 0xACE1 at reset. It advances on every clock after reset as `next = {cur[14:0], cur[15]^cur[13]^cur[12]^cur[10]}`. A flush does not touch it. The victim is bits [1:0] of the register value present in the lookup cycle.
- R3: With the direct policy, the victim is address bits [13:12] of the lookup address. These are the two bits just above the 4 KiB way offset.
- R4: With the round-robin policy, each set keeps a 2-bit pointer, and the victim is that pointer. Every refill of the set adds 1 modulo 4, whatever the refilled way. Hits leave the pointer unchanged.
- R5: With the LRU policy, the victim is the way of the set touched longest ago. Both a hit and a refill make their way the most recent. When a hit and a refill hit the same set in one cycle, the hit is applied first and the refill second.
- R6: A flush sets every round-robin pointer to 0 and every LRU order to way 0, 1, 2, 3, with way 0 the oldest. A flush overrides any hit or refill update in the same cycle.
- R7: After reset, `victim_valid_o` and `victim_o` are 0, and all per-set state equals the state that a flush leaves.
- R8: A hit, refill or flush on one set leaves the replacement state of every other set unchanged, except for the global reset that a flush performs.
- R9: A lookup returns the state as it was before any update made in the same cycle. An update becomes visible to a lookup made in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_i | input | 1 | Request a victim for `lookup_set_i` |
| lookup_set_i | input | SET_W | Set index of the lookup |
| lookup_addr_i | input | ADDR_W | Access address of the lookup |
| hit_i | input | 1 | A hit occurred |
| hit_set_i | input | SET_W | Set of the hit |
| hit_way_i | input | 2 | Way of the hit |
| fill_i | input | 1 | A line was refilled |
| fill_set_i | input | SET_W | Set of the refill |
| fill_way_i | input | 2 | Way written by the refill |
| flush_i | input | 1 | Reset all replacement state |
| victim_valid_o | output | 1 | `victim_o` answers the previous cycle's lookup |
| victim_o | output | 2 | Selected victim way |

## Verification
Corrupt per-set state stays hidden until that set is looked up. It then shows as a wrong `victim_o` one cycle after the lookup. For this reason the stimulus keeps set indices in a narrow range, so that every hit and refill is followed within a few cycles by a lookup of the same set. A wrong LRU code can lurk behind a correct oldest way, but it surfaces after at most three further touches of that set, once the corrupted rank reaches the front. A broken random sequence or wrong address slice shows on the very first lookup, because the bench follows the register value cycle by cycle.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    typedef enum logic [1:0] {
        POL_RANDOM = 2'd0,
        POL_DIRECT = 2'd1,
        POL_LRR    = 2'd2,
        POL_LRU    = 2'd3
    } policy_e;

    localparam int NUM_WAYS   = 4;
    localparam int LRU_CODE_W = 5;

    typedef logic [1:0]            way_t;
    typedef logic [LRU_CODE_W-1:0] lru_code_t;

    // Rank code: code = r0*6 + r1*2 + r2, where r_k is the position of the
    // k-th oldest way among the ways not yet placed. The oldest way equals r0.
    function automatic way_t lru_oldest(lru_code_t code);
        return way_t'(int'(code) / 6);
    endfunction

    function automatic lru_code_t lru_touch(lru_code_t code, way_t way);
        int         rank [NUM_WAYS];
        way_t       ord  [NUM_WAYS];
        way_t       nord [NUM_WAYS];
        logic [3:0] taken;
        int         cnt;
        int         n;
        int         res;
        rank[0] = int'(code) / 6;
        rank[1] = (int'(code) % 6) / 2;
        rank[2] = int'(code) % 2;
        rank[3] = 0;
        taken = '0;
        for (int pos = 0; pos < NUM_WAYS; pos++) begin
            ord[pos] = '0;
            cnt = 0;
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (!taken[w]) begin
                    if (cnt == rank[pos]) begin
                        ord[pos] = way_t'(w);
                    end
                    cnt++;
                end
            end
            taken[ord[pos]] = 1'b1;
        end
        for (int pos = 0; pos < NUM_WAYS; pos++) begin
            nord[pos] = way;
        end
        n = 0;
        for (int pos = 0; pos < NUM_WAYS; pos++) begin
            if (ord[pos] != way) begin
                nord[n[1:0]] = ord[pos];
                n++;
            end
        end
        taken = '0;
        res   = 0;
        for (int pos = 0; pos < NUM_WAYS - 1; pos++) begin
            cnt = 0;
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (w < int'(nord[pos]) && !taken[w]) begin
                    cnt++;
                end
            end
            res = res + cnt * ((pos == 0) ? 6 : ((pos == 1) ? 2 : 1));
            taken[nord[pos]] = 1'b1;
        end
        return lru_code_t'(res);
    endfunction

endpackage

// File: rtl/cvs_lfsr.sv
module cvs_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter logic [15:0] TAPS  = 16'hB400
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [WIDTH-1:0] value_o
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.val = {st_q.val[WIDTH-2:0], ^(st_q.val & TAPS[WIDTH-1:0])};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{val: SEED[WIDTH-1:0]};
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.val;

endmodule

// File: rtl/cvs_state.sv
module cvs_state
    import cvs_pkg::*;
#(
    parameter policy_e POLICY  = POL_LRU,
    parameter int      SETS    = 128,
    parameter int      SET_W   = 7,
    parameter int      ADDR_W  = 32,
    parameter int      WAY_LSB = 12,
    parameter int      RND_W   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SET_W-1:0]  rd_set_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [RND_W-1:0]  rnd_i,
    input  logic              hit_i,
    input  logic [SET_W-1:0]  hit_set_i,
    input  way_t              hit_way_i,
    input  logic              fill_i,
    input  logic [SET_W-1:0]  fill_set_i,
    input  way_t              fill_way_i,
    input  logic              flush_i,
    output way_t              cand_o
);

    if (POLICY == POL_LRU) begin : g_lru
        typedef struct packed {
            lru_code_t [SETS-1:0] code;
        } lru_st_t;

        lru_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (flush_i) begin
                st_d = '0;
            end else begin
                if (hit_i) begin
                    st_d.code[hit_set_i] = lru_touch(st_d.code[hit_set_i], hit_way_i);
                end
                if (fill_i) begin
                    st_d.code[fill_set_i] = lru_touch(st_d.code[fill_set_i], fill_way_i);
                end
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign cand_o = lru_oldest(st_q.code[rd_set_i]);

        logic unused_lru;
        assign unused_lru = ^{rd_addr_i, rnd_i};
    end else if (POLICY == POL_LRR) begin : g_lrr
        typedef struct packed {
            way_t [SETS-1:0] ptr;
        } lrr_st_t;

        lrr_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (flush_i) begin
                st_d = '0;
            end else if (fill_i) begin
                st_d.ptr[fill_set_i] = st_q.ptr[fill_set_i] + 2'd1;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign cand_o = st_q.ptr[rd_set_i];

        logic unused_lrr;
        assign unused_lrr = ^{rd_addr_i, rnd_i, hit_i, hit_set_i, hit_way_i, fill_way_i};
    end else if (POLICY == POL_DIRECT) begin : g_direct
        assign cand_o = rd_addr_i[WAY_LSB+1:WAY_LSB];

        logic unused_dir;
        assign unused_dir = ^{clk_i, rst_ni, rd_set_i, rd_addr_i, rnd_i, hit_i, hit_set_i,
                              hit_way_i, fill_i, fill_set_i, fill_way_i, flush_i};
    end else begin : g_random
        assign cand_o = rnd_i[1:0];

        logic unused_rnd;
        assign unused_rnd = ^{clk_i, rst_ni, rd_set_i, rd_addr_i, rnd_i, hit_i, hit_set_i,
                              hit_way_i, fill_i, fill_set_i, fill_way_i, flush_i};
    end

endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
    import cvs_pkg::*;
#(
    parameter policy_e POLICY     = POL_LRU,
    parameter int      ADDR_W     = 32,
    parameter int      WAY_BYTES  = 4096,
    parameter int      LINE_BYTES = 32,
    localparam int     SETS       = WAY_BYTES / LINE_BYTES,
    localparam int     SET_W      = $clog2(SETS),
    localparam int     WAY_LSB    = $clog2(WAY_BYTES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lookup_i,
    input  logic [SET_W-1:0]  lookup_set_i,
    input  logic [ADDR_W-1:0] lookup_addr_i,
    input  logic              hit_i,
    input  logic [SET_W-1:0]  hit_set_i,
    input  logic [1:0]        hit_way_i,
    input  logic              fill_i,
    input  logic [SET_W-1:0]  fill_set_i,
    input  logic [1:0]        fill_way_i,
    input  logic              flush_i,
    output logic              victim_valid_o,
    output logic [1:0]        victim_o
);

    localparam int RND_W = 16;

    typedef struct packed {
        logic valid;
        way_t victim;
    } out_st_t;

    out_st_t          out_d, out_q;
    logic [RND_W-1:0] rnd;
    way_t             cand;

    cvs_lfsr #(
        .WIDTH (RND_W),
        .SEED  (16'hACE1),
        .TAPS  (16'hB400)
    ) lfsr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .value_o (rnd)
    );

    cvs_state #(
        .POLICY  (POLICY),
        .SETS    (SETS),
        .SET_W   (SET_W),
        .ADDR_W  (ADDR_W),
        .WAY_LSB (WAY_LSB),
        .RND_W   (RND_W)
    ) state_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_set_i   (lookup_set_i),
        .rd_addr_i  (lookup_addr_i),
        .rnd_i      (rnd),
        .hit_i      (hit_i),
        .hit_set_i  (hit_set_i),
        .hit_way_i  (hit_way_i),
        .fill_i     (fill_i),
        .fill_set_i (fill_set_i),
        .fill_way_i (fill_way_i),
        .flush_i    (flush_i),
        .cand_o     (cand)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = lookup_i;
        if (lookup_i) begin
            out_d.victim = cand;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign victim_valid_o = out_q.valid;
    assign victim_o       = out_q.victim;

endmodule

// File: rtl/cvs_checker.sv
module cvs_checker
    import cvs_pkg::*;
#(
    parameter policy_e POLICY  = POL_LRU,
    parameter int      ADDR_W  = 32,
    parameter int      SET_W   = 7,
    parameter int      WAY_LSB = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              lookup_i,
    input logic [SET_W-1:0]  lookup_set_i,
    input logic [ADDR_W-1:0] lookup_addr_i,
    input logic              hit_i,
    input logic [SET_W-1:0]  hit_set_i,
    input logic [1:0]        hit_way_i,
    input logic              fill_i,
    input logic              flush_i,
    input logic              victim_valid_o,
    input logic [1:0]        victim_o
);

    localparam bit IS_DIRECT = (POLICY == POL_DIRECT);
    localparam bit IS_LRU    = (POLICY == POL_LRU);
    localparam bit HAS_STATE = (POLICY == POL_LRU) || (POLICY == POL_LRR);

    AST_VALID_AFTER_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lookup_i |=> victim_valid_o); // R1

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lookup_i |=> !victim_valid_o); // R1

    AST_VICTIM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lookup_i |=> $stable(victim_o)); // R1

    AST_DIRECT_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (IS_DIRECT && lookup_i) |=> victim_o == $past(lookup_addr_i[WAY_LSB+1:WAY_LSB])); // R3

    AST_FLUSH_TO_WAY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (HAS_STATE && lookup_i && $past(flush_i)) |=> victim_o == 2'd0); // R6

    AST_LRU_HIT_NOT_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (IS_LRU && lookup_i && $past(hit_i) && !$past(fill_i) && !$past(flush_i)
         && $past(hit_set_i) == lookup_set_i) |=> victim_o != $past(hit_way_i, 2)); // R5

endmodule

bind cache_victim_sel cvs_checker #(
    .POLICY  (POLICY),
    .ADDR_W  (ADDR_W),
    .SET_W   (SET_W),
    .WAY_LSB (WAY_LSB)
) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lookup_i       (lookup_i),
    .lookup_set_i   (lookup_set_i),
    .lookup_addr_i  (lookup_addr_i),
    .hit_i          (hit_i),
    .hit_set_i      (hit_set_i),
    .hit_way_i      (hit_way_i),
    .fill_i         (fill_i),
    .flush_i        (flush_i),
    .victim_valid_o (victim_valid_o),
    .victim_o       (victim_o)
);

// File: tb/cache_victim_sel_tb_top.sv
module cache_victim_sel_tb_top;
    import cvs_pkg::*;

    localparam int NSETS = 128;
    localparam int SW    = 7;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup = 1'b0;
    logic [SW-1:0] lk_set = '0;
    logic [31:0] lk_addr = '0;
    logic        hit = 1'b0;
    logic [SW-1:0] hit_set = '0;
    logic [1:0]  hit_way = '0;
    logic        fill = 1'b0;
    logic [SW-1:0] fill_set = '0;
    logic [1:0]  fill_way = '0;
    logic        flush = 1'b0;

    logic       vv [4];
    logic [1:0] vw [4];

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string phase = "R7";
    string ptag [4] = '{"R2", "R3", "R4", "R5"};

    always #2 clk = ~clk;

    cache_victim_sel #(.POLICY(POL_LRU)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .lookup_set_i(lk_set),
        .lookup_addr_i(lk_addr), .hit_i(hit), .hit_set_i(hit_set), .hit_way_i(hit_way),
        .fill_i(fill), .fill_set_i(fill_set), .fill_way_i(fill_way), .flush_i(flush),
        .victim_valid_o(vv[3]), .victim_o(vw[3]));

    cache_victim_sel #(.POLICY(POL_RANDOM)) dut_rnd_i (
        .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .lookup_set_i(lk_set),
        .lookup_addr_i(lk_addr), .hit_i(hit), .hit_set_i(hit_set), .hit_way_i(hit_way),
        .fill_i(fill), .fill_set_i(fill_set), .fill_way_i(fill_way), .flush_i(flush),
        .victim_valid_o(vv[0]), .victim_o(vw[0]));

    cache_victim_sel #(.POLICY(POL_DIRECT)) dut_dir_i (
        .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .lookup_set_i(lk_set),
        .lookup_addr_i(lk_addr), .hit_i(hit), .hit_set_i(hit_set), .hit_way_i(hit_way),
        .fill_i(fill), .fill_set_i(fill_set), .fill_way_i(fill_way), .flush_i(flush),
        .victim_valid_o(vv[1]), .victim_o(vw[1]));

    cache_victim_sel #(.POLICY(POL_LRR)) dut_lrr_i (
        .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .lookup_set_i(lk_set),
        .lookup_addr_i(lk_addr), .hit_i(hit), .hit_set_i(hit_set), .hit_way_i(hit_way),
        .fill_i(fill), .fill_set_i(fill_set), .fill_way_i(fill_way), .flush_i(flush),
        .victim_valid_o(vv[2]), .victim_o(vw[2]));

    // Behavioural reference
    int lfsr;
    int lrr_ptr [NSETS];
    int lru_ord [NSETS][4];
    bit exp_valid [4];
    int exp_way [4];

    task automatic m_reset_sets();
        for (int s = 0; s < NSETS; s++) begin
            lrr_ptr[s] = 0;
            for (int k = 0; k < 4; k++) lru_ord[s][k] = k;
        end
    endtask

    task automatic m_touch(int s, int w);
        int pos = 0;
        for (int k = 0; k < 4; k++) if (lru_ord[s][k] == w) pos = k;
        for (int k = pos; k < 3; k++) lru_ord[s][k] = lru_ord[s][k+1];
        lru_ord[s][3] = w;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr = 16'hACE1;
            m_reset_sets();
            for (int p = 0; p < 4; p++) begin
                exp_valid[p] = 1'b0;
                exp_way[p]   = 0;
            end
        end else begin
            cycles++;
            for (int p = 0; p < 4; p++) exp_valid[p] = lookup;
            if (lookup) begin
                exp_way[0] = lfsr % 4;
                exp_way[1] = int'(lk_addr[13:12]);
                exp_way[2] = lrr_ptr[lk_set];
                exp_way[3] = lru_ord[lk_set][0];
            end
            lfsr = ((lfsr << 1) & 16'hFFFF) |
                   (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
            if (flush) begin
                m_reset_sets();
            end else begin
                if (hit) m_touch(int'(hit_set), int'(hit_way));
                if (fill) begin
                    lrr_ptr[fill_set] = (lrr_ptr[fill_set] + 1) % 4;
                    m_touch(int'(fill_set), int'(fill_way));
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                for (int p = 0; p < 4; p++) begin
                    checks++;
                    if (vv[p] !== 1'b0 || vw[p] !== 2'd0) begin
                        errors++;
                        $display("FAIL R7 reset policy %0d: valid=%0b way=%0d expected 0/0",
                                 p, vv[p], vw[p]);
                    end
                end
            end else begin
                for (int p = 0; p < 4; p++) begin
                    checks++;
                    if (vv[p] !== exp_valid[p]) begin
                        errors++;
                        $display("FAIL R1 (%s) policy %0d: valid=%0b expected %0b",
                                 phase, p, vv[p], exp_valid[p]);
                    end else if (int'(vw[p]) != exp_way[p]) begin
                        errors++;
                        $display("FAIL %s (%s): victim=%0d expected %0d",
                                 ptag[p], phase, vw[p], exp_way[p]);
                    end
                end
            end
        end
    end

    task automatic drive(bit lk, int ls, logic [31:0] la, bit h, int hs, int hw,
                         bit f, int fs, int fw, bit fl);
        @(negedge clk);
        lookup = lk; lk_set = SW'(ls); lk_addr = la;
        hit = h; hit_set = SW'(hs); hit_way = 2'(hw);
        fill = f; fill_set = SW'(fs); fill_way = 2'(fw);
        flush = fl;
    endtask

    task automatic idle();
        drive(0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic look(int s, logic [31:0] a);
        drive(1, s, a, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7: state after reset equals flushed state
        phase = "R7";
        look(5, 32'h0000_3000);
        look(9, 32'h0000_1000);
        idle();
        // R5: hits and refills reorder one set
        phase = "R5";
        drive(0, 0, 0, 1, 5, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 5, 2, 0, 0, 0, 0);
        look(5, 32'h0000_2000);
        drive(0, 0, 0, 0, 0, 0, 1, 5, 1, 0);
        look(5, 32'h0000_1000);
        drive(0, 0, 0, 1, 5, 3, 1, 5, 3, 0);
        look(5, 32'h0);
        // R4: hits do not move the round-robin pointer
        phase = "R4";
        drive(0, 0, 0, 1, 9, 0, 0, 0, 0, 0);
        look(9, 32'h0);
        drive(0, 0, 0, 0, 0, 0, 1, 9, 2, 0);
        look(9, 32'h0);
        // R9: a same-cycle update is not seen, the next lookup sees it
        phase = "R9";
        drive(1, 9, 32'h0, 1, 9, 1, 1, 9, 0, 0);
        look(9, 32'h0);
        // R8: other sets are untouched
        phase = "R8";
        drive(0, 0, 0, 1, 6, 0, 1, 6, 0, 0);
        look(5, 32'h0);
        look(6, 32'h0);
        look(7, 32'h0);
        // R6: flush wins over same-cycle updates
        phase = "R6";
        drive(0, 0, 0, 1, 5, 0, 1, 9, 0, 1);
        look(5, 32'h0);
        look(9, 32'h0);
        look(6, 32'h0);
        idle();
        // R3 and R2: varied addresses and random traffic on few sets
        phase = "R3";
        for (int i = 0; i < 16; i++) look(i % 4, 32'(i) << 12);
        phase = "R2";
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 3) != 0, int'($urandom % 8), $urandom,
                  ($urandom % 2) == 0, int'($urandom % 8), int'($urandom % 4),
                  ($urandom % 3) == 0, int'($urandom % 8), int'($urandom % 4),
                  ($urandom % 200) == 0);
        end
        idle();
        idle();
        finish_run();
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run exceeded %0d cycles, expected completion", MAX_CYCLES);
        finish_run();
    end

endmodule